// File: doc/BRIEF.md
# Cascadable Down-Counter Timer Pair

The block holds two programmable timers that share one register port: a 24-bit low timer and a 32-bit high timer. Each timer picks one of four tick-enable strobes as its time base (the strobes stand in for four slow-to-fast clock sources). It counts down from a reload value, reloads on reaching zero and signals a terminal-count event. The event appears as a one-cycle interrupt pulse and as a sticky pending bit that software clears by writing one to it.

A control bit on the low timer chains the pair into one 56-bit timer. In that mode the high timer ignores its own strobe and enable, and advances by one each time the low timer reaches its terminal count. It starts from the bitwise inverse of its reload value, so its readback rises. When it wraps past all ones it reloads that inverse and raises its own interrupt. The low carry, the low reload and the high increment all take effect on the same clock edge, so no single read ever returns a half-updated pair.

Top module: `tmr_pair`

## Requirements
- R1: After reset every readable register reads zero and both interrupt outputs are low.
- R2: The register map uses word addresses 0 to 6: 0 low control, 1 low reload, 2 low count, 3 high control, 4 high reload, 5 high count, 6 status. In both control registers bit 0 is enable and bits 5:4 select the tick strobe `tick_i[sel]`. Bit 3 of the low control register is combine. Unused bits read zero.
- R3: An enabled independent timer decrements by one on each cycle in which its selected strobe is high. Strobes it has not selected have no effect.
- R4: When an enabled timer is at zero and its strobe is high, it reloads from its reload register. It also drives its interrupt output (`irq_lo` or `irq_hi`) high for exactly one cycle and sets its pending bit (status bit 0 for low, bit 1 for high).
- R5: Writing a control register with bit 1 set loads the counter from its reload register on that write. Bit 1 is not stored and reads back as zero.
- R6: While a timer is disabled its count holds. A reload write made meanwhile does not change the count until a restart or reload.
- R7: In combine mode each low terminal count increments the high counter by one. The high timer's own strobe and enable have no effect on it.
- R8: In combine mode a restart loads the high counter with the inverse of its reload value. A restart of the low timer in combine mode restarts both timers. For example, a high reload of 0x000007FF reads back as 0xFFFFF800.
- R9: In combine mode, a low terminal count while the high counter is all ones reloads the high counter with the inverse of its reload value and raises `irq_hi` and status bit 1. On the same edge the low counter reloads and raises `irq_lo`.
- R10: Writing status clears each pending bit written as one and leaves the others. A terminal count in the same cycle as a clear of its bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 4 | Tick-enable strobes, one per time base |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_lo | output | 1 | One-cycle pulse on low timer terminal count |
| irq_hi | output | 1 | One-cycle pulse on high timer terminal count or combined overflow |

## Verification
Two functions meet on one edge here. One is a terminal count that sets a pending bit. The other is a software write-one-to-clear of that same bit. The bench parks the low counter at zero with the high counter at all ones in combine mode. It then drives the selected strobe and a status write that clears both bits in the same cycle. It judges the pair by both pending bits reading back as set, with the high counter already reloaded. A second case has the low reload, the carry into the high counter and the high wrap all happen on one edge. After that edge, both counts and both interrupt pulses are read back before the next edge.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_LO_CTRL = 3'd0,
      RA_LO_RLD  = 3'd1,
      RA_LO_CNT  = 3'd2,
      RA_HI_CTRL = 3'd3,
      RA_HI_RLD  = 3'd4,
      RA_HI_CNT  = 3'd5,
      RA_STATUS  = 3'd6
   } reg_addr_e;

   localparam int CB_EN      = 0;
   localparam int CB_RESTART = 1;
   localparam int CB_COMBINE = 3;
   localparam int CB_SEL_LSB = 4;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_SRC-1:0] ticks,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   generate
      if ((1 << SEL_W) == NUM_SRC) begin : g_full
         assign tick = ticks[sel];
      end else begin : g_sparse
         always_comb begin
            tick = 1'b0;
            for (int i = 0; i < NUM_SRC; i++)
               if (int'(sel) == i) tick = ticks[i];
         end
      end
   endgenerate
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic         restart,
   input  logic [W-1:0] reload,
   output logic [W-1:0] count,
   output logic         tc
);
   logic at_zero;
   assign at_zero = (count == '0);
   assign tc      = run && tick && at_zero && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (restart)
         count <= reload;
      else if (run && tick)
         count <= at_zero ? reload : count - 1'b1;
   end

   p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(count));
   p_reload_on_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> (count == $past(reload)));
   p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !restart && !at_zero) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/tmr_hi_cnt.sv
module tmr_hi_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         combine,
   input  logic         run,
   input  logic         tick,
   input  logic         carry_in,
   input  logic         restart,
   input  logic [W-1:0] reload,
   output logic [W-1:0] count,
   output logic         tc
);
   logic         step;
   logic         at_end;
   logic [W-1:0] start_val;

   assign start_val = combine ? ~reload : reload;
   assign step      = combine ? carry_in : (run && tick);
   assign at_end    = combine ? (count == '1) : (count == '0);
   assign tc        = step && at_end && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (restart)
         count <= start_val;
      else if (step) begin
         if (at_end)       count <= start_val;
         else if (combine) count <= count + 1'b1;
         else              count <= count - 1'b1;
      end
   end

   p_comb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (combine && !carry_in && !restart) |=> $stable(count));
   p_comb_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (combine && carry_in && !restart && count != '1) |=> (count == $past(count) + 1'b1));
   p_comb_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (combine && tc) |=> (count == ~$past(reload)));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pair_pkg::*;
#(
   parameter int LO_W    = 24,
   parameter int HI_W    = 32,
   parameter int DATA_W  = 32,
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] tick_i,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_lo,
   output logic               irq_hi
);
   localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   generate
      if (LO_W > DATA_W || HI_W > DATA_W) begin : g_bad_width
         $error("timer width exceeds register data width");
      end
      if (CB_SEL_LSB + SEL_W > DATA_W) begin : g_bad_sel
         $error("clock select field does not fit the control register");
      end
   endgenerate

   logic             lo_en, hi_en, comb;
   logic [SEL_W-1:0] lo_sel, hi_sel;
   logic [LO_W-1:0]  lo_rld, lo_cnt;
   logic [HI_W-1:0]  hi_rld, hi_cnt;
   logic [1:0]       pend;
   logic             lo_tick, hi_tick, lo_tc, hi_tc;
   logic             wr_lo_ctrl, wr_hi_ctrl, wr_status;
   logic             lo_restart, hi_restart, comb_now;

   assign wr_lo_ctrl = reg_we && (reg_addr == RA_LO_CTRL);
   assign wr_hi_ctrl = reg_we && (reg_addr == RA_HI_CTRL);
   assign wr_status  = reg_we && (reg_addr == RA_STATUS);
   assign comb_now   = wr_lo_ctrl ? reg_wdata[CB_COMBINE] : comb;
   assign lo_restart = wr_lo_ctrl && reg_wdata[CB_RESTART];
   assign hi_restart = (wr_hi_ctrl && reg_wdata[CB_RESTART]) ||
                       (lo_restart && reg_wdata[CB_COMBINE]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_en  <= 1'b0;
         hi_en  <= 1'b0;
         comb   <= 1'b0;
         lo_sel <= '0;
         hi_sel <= '0;
         lo_rld <= '0;
         hi_rld <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            RA_LO_CTRL: begin
               lo_en  <= reg_wdata[CB_EN];
               comb   <= reg_wdata[CB_COMBINE];
               lo_sel <= reg_wdata[CB_SEL_LSB +: SEL_W];
            end
            RA_HI_CTRL: begin
               hi_en  <= reg_wdata[CB_EN];
               hi_sel <= reg_wdata[CB_SEL_LSB +: SEL_W];
            end
            RA_LO_RLD: lo_rld <= reg_wdata[LO_W-1:0];
            RA_HI_RLD: hi_rld <= reg_wdata[HI_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= '0;
         irq_lo <= 1'b0;
         irq_hi <= 1'b0;
      end else begin
         pend   <= (pend & ~(wr_status ? reg_wdata[1:0] : 2'b00)) | {hi_tc, lo_tc};
         irq_lo <= lo_tc;
         irq_hi <= hi_tc;
      end
   end

   tmr_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_lo_sel (
      .ticks(tick_i), .sel(lo_sel), .tick(lo_tick));
   tmr_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_hi_sel (
      .ticks(tick_i), .sel(hi_sel), .tick(hi_tick));

   tmr_down_cnt #(.W(LO_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .run(lo_en), .tick(lo_tick),
      .restart(lo_restart), .reload(lo_rld), .count(lo_cnt), .tc(lo_tc));

   tmr_hi_cnt #(.W(HI_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .combine(comb_now), .run(hi_en),
      .tick(hi_tick), .carry_in(lo_tc), .restart(hi_restart),
      .reload(hi_rld), .count(hi_cnt), .tc(hi_tc));

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_LO_CTRL: begin
            reg_rdata[CB_EN]                 = lo_en;
            reg_rdata[CB_COMBINE]            = comb;
            reg_rdata[CB_SEL_LSB +: SEL_W]   = lo_sel;
         end
         RA_HI_CTRL: begin
            reg_rdata[CB_EN]                 = hi_en;
            reg_rdata[CB_SEL_LSB +: SEL_W]   = hi_sel;
         end
         RA_LO_RLD: reg_rdata = DATA_W'(lo_rld);
         RA_HI_RLD: reg_rdata = DATA_W'(hi_rld);
         RA_LO_CNT: reg_rdata = DATA_W'(lo_cnt);
         RA_HI_CNT: reg_rdata = DATA_W'(hi_cnt);
         RA_STATUS: reg_rdata[1:0] = pend;
         default: ;
      endcase
   end

   p_lo_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lo_tc |=> (irq_lo && pend[0]));
   p_hi_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hi_tc |=> (irq_hi && pend[1]));
   p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lo && !lo_tc) |=> !irq_lo);
   p_wrap_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (comb && hi_tc) |=> (irq_lo && irq_hi));
endmodule

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tick_i = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_lo, irq_hi;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   tmr_pair dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_lo(irq_lo), .irq_hi(irq_hi));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic tick(input int idx);
      @(negedge clk);
      tick_i = '0; tick_i[idx] = 1'b1;
      @(negedge clk);
      tick_i = '0;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 7; a++) rd_chk("R1 reg", 3'(a), 32'h0);
      chk("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
      chk("R1 irq_hi", {31'b0, irq_hi}, 32'h0);
   endtask

   task automatic t_lo_basic();
      wr(3'd1, 32'h3);
      wr(3'd0, 32'h3);
      rd_chk("R5 restart load", 3'd2, 32'h3);
      rd_chk("R5 restart bit not stored", 3'd0, 32'h1);
      tick(1);
      rd_chk("R3 unselected strobe", 3'd2, 32'h3);
      tick(0);
      rd_chk("R3 decrement", 3'd2, 32'h2);
      tick(0);
      tick(0);
      rd_chk("R3 at zero", 3'd2, 32'h0);
      chk("R4 no irq before reload", {31'b0, irq_lo}, 32'h0);
      tick(0);
      rd_chk("R4 reload", 3'd2, 32'h3);
      chk("R4 irq_lo pulse", {31'b0, irq_lo}, 32'h1);
      rd_chk("R4 pending lo", 3'd6, 32'h1);
      @(negedge clk);
      chk("R4 irq_lo one cycle", {31'b0, irq_lo}, 32'h0);
   endtask

   task automatic t_w1c();
      wr(3'd6, 32'h2);
      rd_chk("R10 zero bit leaves pending", 3'd6, 32'h1);
      wr(3'd6, 32'h1);
      rd_chk("R10 one bit clears", 3'd6, 32'h0);
   endtask

   task automatic t_disable();
      wr(3'd0, 32'h0);
      tick(0);
      rd_chk("R6 hold while disabled", 3'd2, 32'h3);
      wr(3'd1, 32'h9);
      rd_chk("R6 reload write no effect", 3'd2, 32'h3);
      wr(3'd0, 32'h2);
      rd_chk("R5 restart while disabled", 3'd2, 32'h9);
      tick(0);
      rd_chk("R6 still held", 3'd2, 32'h9);
      wr(3'd0, 32'h1);
      tick(0);
      rd_chk("R3 resumes", 3'd2, 32'h8);
   endtask

   task automatic t_hi_indep();
      wr(3'd4, 32'h1);
      wr(3'd3, 32'h23);
      rd_chk("R2 hi ctrl readback", 3'd3, 32'h21);
      rd_chk("R5 hi restart", 3'd5, 32'h1);
      tick(2);
      rd_chk("R3 hi decrement", 3'd5, 32'h0);
      rd_chk("R3 lo ignores strobe 2", 3'd2, 32'h8);
      tick(2);
      rd_chk("R4 hi reload", 3'd5, 32'h1);
      chk("R4 irq_hi pulse", {31'b0, irq_hi}, 32'h1);
      rd_chk("R4 pending hi", 3'd6, 32'h2);
      wr(3'd6, 32'h3);
      rd_chk("R10 clear hi", 3'd6, 32'h0);
   endtask

   task automatic t_combine();
      wr(3'd1, 32'h1);
      wr(3'd4, 32'h0000_07FF);
      wr(3'd0, 32'h0B);
      rd_chk("R2 lo ctrl combine readback", 3'd0, 32'h9);
      rd_chk("R8 lo restart", 3'd2, 32'h1);
      rd_chk("R8 inverse load", 3'd5, 32'hFFFF_F800);
      tick(2);
      rd_chk("R7 hi strobe ignored", 3'd5, 32'hFFFF_F800);
      tick(0);
      rd_chk("R7 no carry yet", 3'd5, 32'hFFFF_F800);
      tick(0);
      rd_chk("R7 carry increments", 3'd5, 32'hFFFF_F801);
      rd_chk("R9 lo reload with carry", 3'd2, 32'h1);
      chk("R7 irq_lo on carry", {31'b0, irq_lo}, 32'h1);
      chk("R7 no irq_hi on carry", {31'b0, irq_hi}, 32'h0);
      wr(3'd4, 32'h0);
      rd_chk("R6 hi reload write keeps count", 3'd5, 32'hFFFF_F801);
      wr(3'd0, 32'h0B);
      rd_chk("R8 restart to all ones", 3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'h3);
      tick(0);
      tick(0);
      rd_chk("R9 hi wrap reload", 3'd5, 32'hFFFF_FFFF);
      rd_chk("R9 lo reload", 3'd2, 32'h1);
      chk("R9 irq_hi", {31'b0, irq_hi}, 32'h1);
      chk("R9 irq_lo", {31'b0, irq_lo}, 32'h1);
      rd_chk("R9 both pending", 3'd6, 32'h3);
   endtask

   task automatic t_race();
      wr(3'd6, 32'h3);
      rd_chk("R10 cleared before race", 3'd6, 32'h0);
      tick(0);
      rd_chk("R10 lo parked at zero", 3'd2, 32'h0);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h3; tick_i = 4'b0001;
      @(negedge clk);
      reg_we = 1'b0; tick_i = '0;
      rd_chk("R10 set wins over clear", 3'd6, 32'h3);
      rd_chk("R9 hi wrapped in race", 3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'h2);
      rd_chk("R10 partial clear", 3'd6, 32'h1);
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lo_basic();
      t_w1c();
      t_disable();
      t_hi_indep();
      t_combine();
      t_race();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule